// File: doc/BRIEF.md
# Operand Bypass and Load Interlock Controller

This block is the hazard controller for an in-order integer pipeline with five stages: fetch, decode with register read, execute, memory access and write back. It keeps a small shadow copy of the control fields that travel down the pipeline. These fields are the source specifiers and their use flags, the destination specifier, the write enable, a load flag and a valid bit, held for the instructions in the execute, memory and write-back slots. From this copy it works out, every cycle, where each ALU operand of the instruction in execute must come from.

The decode stage presents its instruction's control fields on the `id_*` inputs. When that instruction reads a register that a load now in execute will write, the block holds the program counter and the fetch/decode register for one cycle and turns the next execute slot into an empty bubble. A redirect input from branch resolution discards the two youngest instructions: the fetch/decode register is cleared and the next execute slot becomes a bubble. The datapath acts on the select, hold, clear and bubble outputs. The block never sees data values.

Top module: `hz_unit`

## Requirements
- R1: While reset is active, and after it is released with no valid instruction presented, both operand selects read 2'b00, and `pc_hold`, `ifid_hold`, `ifid_flush` and `idex_bubble` are all 0.
- R2: An operand select reads 2'b10 (bypass from the memory-stage register) when the operand's source is in use and equals the destination of the instruction one stage ahead, and that instruction is valid, has write enable set and writes a nonzero register.
- R3: An operand select reads 2'b01 (bypass from the write-back-stage register) when the same match is found only against the instruction two stages ahead.
- R4: When both older instructions write the register an operand reads, that operand's select reads 2'b10. The nearer result wins.
- R5: An operand select reads 2'b00 (register file) when no match exists or when its source-use flag is 0. Operand A follows source 1 and operand B follows source 2, each on its own.
- R6: A valid decode instruction that uses a source equal to the nonzero destination of a valid, write-enabled load now in execute causes `pc_hold`, `ifid_hold` and `idex_bubble` to be 1 in that cycle. In the next cycle the stall is gone and the operand selects read 2'b00. One cycle later the held consumer reads 2'b01 for that operand.
- R7: A load separated from its consumer by one instruction causes no stall, and the consumer reads 2'b01. A load followed at once by an instruction that does not use that register causes no stall.
- R8: Register 0 and producers with write enable 0 never cause a bypass or a stall.
- R9: With `redirect` at 1, `ifid_flush` and `idex_bubble` are 1 and both holds are 0, even when a load-use match is present. The decode instruction of that cycle never becomes a bypass source for later instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| id_valid | input | 1 | Decode slot holds a real instruction |
| id_rs1 | input | 5 | Source 1 specifier in decode |
| id_rs1_used | input | 1 | Source 1 is read by the instruction |
| id_rs2 | input | 5 | Source 2 specifier in decode |
| id_rs2_used | input | 1 | Source 2 is read by the instruction |
| id_rd | input | 5 | Destination specifier in decode |
| id_wen | input | 1 | Instruction writes its destination |
| id_load | input | 1 | Instruction is a memory load |
| redirect | input | 1 | Branch misprediction: discard the two youngest instructions |
| fwd_a_sel | output | 2 | Operand A source: 00 register file, 01 write-back stage, 10 memory stage |
| fwd_b_sel | output | 2 | Operand B source, same encoding |
| pc_hold | output | 1 | Keep the program counter unchanged |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged |
| ifid_flush | output | 1 | Clear the fetch/decode register to an empty slot |
| idex_bubble | output | 1 | Load an empty slot into the decode/execute register |

## Verification
A corrupted shadow stage shows at the operand selects within one or two cycles. An entry that was not cleared on a redirect or a stall later shows up as a false 2'b10 or 2'b01 select. A lost entry shows up as a 2'b00 select where a bypass was due. A stall that fails to release shows as `pc_hold` staying at 1 for a second cycle. A stall that fails to rise shows as the consumer taking 2'b10 from a load, where the one-cycle delay followed by 2'b01 was due. Each scenario is followed cycle by cycle at the ports, so each of these faults appears as a wrong value in a known cycle.

// File: rtl/hz_pkg.sv
package hz_pkg;

  localparam int REG_AW  = 5;
  localparam int NUM_SRC = 2;

  typedef enum logic [1:0] {
    FWD_RF    = 2'b00,
    FWD_MEMWB = 2'b01,
    FWD_EXMEM = 2'b10
  } fwd_sel_e;

  typedef struct packed {
    logic                             valid;
    logic [REG_AW-1:0]                rd;
    logic                             wen;
    logic                             load;
    logic [NUM_SRC-1:0]               src_used;
    logic [NUM_SRC-1:0][REG_AW-1:0]   src;
  } stage_ctrl_t;

  // A slot produces a register result that others may depend on.
  function automatic logic produces(input stage_ctrl_t c);
    return c.valid && c.wen && (c.rd != '0);
  endfunction

endpackage

// File: rtl/hz_ctrl_pipe.sv
module hz_ctrl_pipe
  import hz_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  stage_ctrl_t id_ctrl,
  input  logic        kill_idex,
  output stage_ctrl_t idex_q,
  output stage_ctrl_t exmem_q,
  output stage_ctrl_t memwb_q
);

  stage_ctrl_t idex_d;
  stage_ctrl_t exmem_d;
  stage_ctrl_t memwb_d;
  logic        adv_en;

  // The shadow control stages advance every cycle; stall and flush act
  // through the bubble inserted into the execute slot.
  assign adv_en = 1'b1;

  always_comb begin
    idex_d  = kill_idex ? '0 : id_ctrl;
    exmem_d = idex_q;
    memwb_d = exmem_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idex_q  <= '0;
      exmem_q <= '0;
      memwb_q <= '0;
    end else if (adv_en) begin
      idex_q  <= idex_d;
      exmem_q <= exmem_d;
      memwb_q <= memwb_d;
    end
  end

  AST_KILLED_SLOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    kill_idex |=> (!idex_q.valid && !idex_q.wen && !idex_q.load)) else $error("killed slot not empty"); // R9

endmodule

// File: rtl/hz_fwd_sel.sv
module hz_fwd_sel
  import hz_pkg::*;
(
  input  logic [REG_AW-1:0] src,
  input  logic              used,
  input  stage_ctrl_t       exmem,
  input  stage_ctrl_t       memwb,
  output fwd_sel_e          sel
);

  logic hit_exmem;
  logic hit_memwb;

  always_comb begin
    hit_exmem = used && produces(exmem) && (exmem.rd == src);
    hit_memwb = used && produces(memwb) && (memwb.rd == src);
  end

  // Nearer producer first: it holds the more recent value of the register.
  always_comb begin
    if (hit_exmem)      sel = FWD_EXMEM;
    else if (hit_memwb) sel = FWD_MEMWB;
    else                sel = FWD_RF;
  end

endmodule

// File: rtl/hz_interlock.sv
module hz_interlock
  import hz_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  stage_ctrl_t id_ctrl,
  input  stage_ctrl_t idex,
  input  logic        redirect,
  output logic        pc_hold,
  output logic        ifid_hold,
  output logic        ifid_flush,
  output logic        idex_bubble
);

  logic [NUM_SRC-1:0] src_hit;
  logic               load_use;
  logic               stall;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign src_hit[g] = id_ctrl.src_used[g] && (id_ctrl.src[g] == idex.rd);
  end

  always_comb begin
    load_use = id_ctrl.valid && idex.load && produces(idex) && (|src_hit);
    // A redirect discards the consumer anyway, so it cancels the stall.
    stall       = load_use && !redirect;
    pc_hold     = stall;
    ifid_hold   = stall;
    ifid_flush  = redirect;
    idex_bubble = stall || redirect;
  end

  AST_FLUSH_OVER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (!pc_hold && !ifid_hold && ifid_flush && idex_bubble)) else $error("flush did not win"); // R9

  AST_STALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    pc_hold |=> !pc_hold) else $error("stall lasted more than one cycle"); // R6

  AST_STALL_BUBBLES: assert property (@(posedge clk) disable iff (!rst_n)
    ifid_hold |-> idex_bubble) else $error("stall without bubble"); // R6

endmodule

// File: rtl/hz_unit.sv
module hz_unit
  import hz_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              id_valid,
  input  logic [REG_AW-1:0] id_rs1,
  input  logic              id_rs1_used,
  input  logic [REG_AW-1:0] id_rs2,
  input  logic              id_rs2_used,
  input  logic [REG_AW-1:0] id_rd,
  input  logic              id_wen,
  input  logic              id_load,
  input  logic              redirect,
  output logic [1:0]        fwd_a_sel,
  output logic [1:0]        fwd_b_sel,
  output logic              pc_hold,
  output logic              ifid_hold,
  output logic              ifid_flush,
  output logic              idex_bubble
);

  stage_ctrl_t id_ctrl;
  stage_ctrl_t idex;
  stage_ctrl_t exmem;
  stage_ctrl_t memwb;
  fwd_sel_e    op_sel [NUM_SRC];

  always_comb begin
    id_ctrl          = '0;
    id_ctrl.valid    = id_valid;
    id_ctrl.rd       = id_rd;
    id_ctrl.wen      = id_wen;
    id_ctrl.load     = id_load;
    id_ctrl.src_used = {id_rs2_used, id_rs1_used};
    id_ctrl.src[0]   = id_rs1;
    id_ctrl.src[1]   = id_rs2;
  end

  hz_ctrl_pipe u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .id_ctrl   (id_ctrl),
    .kill_idex (idex_bubble),
    .idex_q    (idex),
    .exmem_q   (exmem),
    .memwb_q   (memwb)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_op
    hz_fwd_sel u_sel (
      .src   (idex.src[g]),
      .used  (idex.src_used[g]),
      .exmem (exmem),
      .memwb (memwb),
      .sel   (op_sel[g])
    );

    AST_NEAR_PRODUCER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (produces(exmem) && produces(memwb) && (exmem.rd == memwb.rd) &&
       idex.src_used[g] && (idex.src[g] == exmem.rd)) |-> (op_sel[g] == FWD_EXMEM))
      else $error("older result won over nearer one"); // R4

    AST_NO_ZERO_REG_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel[g] != FWD_RF) |-> (idex.src[g] != '0)) else $error("bypass of register 0"); // R8

    AST_UNUSED_SRC_FROM_RF: assert property (@(posedge clk) disable iff (!rst_n)
      !idex.src_used[g] |-> (op_sel[g] == FWD_RF)) else $error("bypass on unused source"); // R5
  end

  assign fwd_a_sel = op_sel[0];
  assign fwd_b_sel = op_sel[1];

  hz_interlock u_lock (
    .clk         (clk),
    .rst_n       (rst_n),
    .id_ctrl     (id_ctrl),
    .idex        (idex),
    .redirect    (redirect),
    .pc_hold     (pc_hold),
    .ifid_hold   (ifid_hold),
    .ifid_flush  (ifid_flush),
    .idex_bubble (idex_bubble)
  );

endmodule

// File: tb/tb_hz_unit.sv
`timescale 1ns/1ps
module tb_hz_unit;
  import hz_pkg::*;

  logic              clk;
  logic              rst_n;
  logic              id_valid;
  logic [REG_AW-1:0] id_rs1;
  logic              id_rs1_used;
  logic [REG_AW-1:0] id_rs2;
  logic              id_rs2_used;
  logic [REG_AW-1:0] id_rd;
  logic              id_wen;
  logic              id_load;
  logic              redirect;
  logic [1:0]        fwd_a_sel;
  logic [1:0]        fwd_b_sel;
  logic              pc_hold;
  logic              ifid_hold;
  logic              ifid_flush;
  logic              idex_bubble;

  int n_chk  = 0;
  int n_fail = 0;

  hz_unit dut (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic put(input logic v, input logic [REG_AW-1:0] r1, input logic u1,
                     input logic [REG_AW-1:0] r2, input logic u2,
                     input logic [REG_AW-1:0] rd, input logic w, input logic ld);
    id_valid = v; id_rs1 = r1; id_rs1_used = u1; id_rs2 = r2; id_rs2_used = u2;
    id_rd = rd; id_wen = w; id_load = ld;
  endtask

  task automatic nop();
    put(1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic drain();
    redirect = 1'b0;
    nop();
    repeat (3) tick();
  endtask

  task automatic t_reset();
    chk("R1", "fwd_a", fwd_a_sel, 0);
    chk("R1", "fwd_b", fwd_b_sel, 0);
    chk("R1", "pc_hold", pc_hold, 0);
    chk("R1", "ifid_hold", ifid_hold, 0);
    chk("R1", "ifid_flush", ifid_flush, 0);
    chk("R1", "idex_bubble", idex_bubble, 0);
  endtask

  task automatic t_near_bypass();
    drain();
    put(1, 5'd1, 1, 5'd2, 1, 5'd3, 1, 0); tick();
    put(1, 5'd3, 1, 5'd4, 1, 5'd8, 1, 0); tick();
    chk("R2", "a from near stage", fwd_a_sel, 2);
    chk("R5", "b no match", fwd_b_sel, 0);
    nop(); tick();
    drain();
    put(1, 5'd1, 1, 5'd2, 1, 5'd11, 1, 0); tick();
    put(1, 5'd4, 1, 5'd11, 1, 5'd8, 1, 0); tick();
    chk("R2", "b from near stage", fwd_b_sel, 2);
    chk("R5", "a no match", fwd_a_sel, 0);
  endtask

  task automatic t_far_bypass();
    drain();
    put(1, 5'd1, 1, 5'd2, 1, 5'd6, 1, 0); tick();
    nop(); tick();
    put(1, 5'd7, 1, 5'd6, 1, 5'd8, 1, 0); tick();
    chk("R3", "b from far stage", fwd_b_sel, 1);
    chk("R3", "a stays rf", fwd_a_sel, 0);
  endtask

  task automatic t_priority();
    drain();
    put(1, 5'd1, 1, 5'd2, 1, 5'd9, 1, 0); tick();
    put(1, 5'd1, 1, 5'd2, 1, 5'd9, 1, 0); tick();
    put(1, 5'd9, 1, 5'd9, 1, 5'd12, 1, 0); tick();
    chk("R4", "a nearer wins", fwd_a_sel, 2);
    chk("R4", "b nearer wins", fwd_b_sel, 2);
    drain();
    put(1, 5'd1, 1, 5'd2, 1, 5'd9, 1, 0); tick();
    put(1, 5'd1, 1, 5'd2, 1, 5'd10, 1, 0); tick();
    put(1, 5'd9, 1, 5'd10, 1, 5'd12, 1, 0); tick();
    chk("R5", "a far, independent", fwd_a_sel, 1);
    chk("R5", "b near, independent", fwd_b_sel, 2);
  endtask

  task automatic t_unused();
    drain();
    put(1, 5'd1, 1, 5'd2, 1, 5'd3, 1, 0); tick();
    put(1, 5'd3, 0, 5'd3, 0, 5'd8, 1, 0); tick();
    chk("R5", "a unused source", fwd_a_sel, 0);
    chk("R5", "b unused source", fwd_b_sel, 0);
  endtask

  task automatic t_zero_and_nowen();
    drain();
    put(1, 5'd1, 1, 5'd2, 1, 5'd0, 1, 0); tick();
    put(1, 5'd0, 1, 5'd0, 1, 5'd8, 1, 0); tick();
    chk("R8", "r0 a", fwd_a_sel, 0);
    chk("R8", "r0 b", fwd_b_sel, 0);
    drain();
    put(1, 5'd1, 1, 5'd2, 1, 5'd4, 0, 0); tick();
    put(1, 5'd4, 1, 5'd2, 1, 5'd8, 1, 0); tick();
    chk("R8", "no-wen producer", fwd_a_sel, 0);
    drain();
    put(1, 5'd1, 1, 5'd2, 1, 5'd0, 1, 1); tick();
    put(1, 5'd0, 1, 5'd0, 1, 5'd8, 1, 0); #1;
    chk("R8", "load r0 no stall", pc_hold, 0);
    drain();
    put(1, 5'd1, 1, 5'd2, 1, 5'd5, 0, 1); tick();
    put(1, 5'd5, 1, 5'd2, 1, 5'd8, 1, 0); #1;
    chk("R8", "load without wen no stall", pc_hold, 0);
  endtask

  task automatic t_load_use();
    drain();
    put(1, 5'd1, 1, 5'd2, 1, 5'd5, 1, 1); tick();
    put(1, 5'd5, 1, 5'd2, 1, 5'd8, 1, 0); #1;
    chk("R6", "pc_hold", pc_hold, 1);
    chk("R6", "ifid_hold", ifid_hold, 1);
    chk("R6", "idex_bubble", idex_bubble, 1);
    chk("R6", "no flush", ifid_flush, 0);
    tick(); #1;
    chk("R6", "stall released", pc_hold, 0);
    chk("R6", "bubble in execute", fwd_a_sel, 0);
    tick();
    chk("R6", "consumer far bypass", fwd_a_sel, 1);
    drain();
    put(1, 5'd1, 1, 5'd2, 1, 5'd13, 1, 1); tick();
    put(1, 5'd3, 1, 5'd13, 1, 5'd8, 1, 0); #1;
    chk("R6", "rs2 stall", ifid_hold, 1);
    tick(); tick();
    chk("R6", "rs2 far bypass", fwd_b_sel, 1);
  endtask

  task automatic t_load_gap();
    drain();
    put(1, 5'd1, 1, 5'd2, 1, 5'd5, 1, 1); tick();
    nop(); #1;
    chk("R7", "gap slot no stall", pc_hold, 0);
    tick();
    put(1, 5'd5, 1, 5'd2, 1, 5'd8, 1, 0); #1;
    chk("R7", "gap consumer no stall", pc_hold, 0);
    tick();
    chk("R7", "gap consumer far bypass", fwd_a_sel, 1);
    drain();
    put(1, 5'd1, 1, 5'd2, 1, 5'd5, 1, 1); tick();
    put(1, 5'd5, 0, 5'd6, 1, 5'd8, 1, 0); #1;
    chk("R7", "non-user no stall", pc_hold, 0);
  endtask

  task automatic t_flush();
    drain();
    put(1, 5'd1, 1, 5'd2, 1, 5'd5, 1, 1); tick();
    put(1, 5'd5, 1, 5'd2, 1, 5'd8, 1, 0); redirect = 1'b1; #1;
    chk("R9", "pc_hold low", pc_hold, 0);
    chk("R9", "ifid_hold low", ifid_hold, 0);
    chk("R9", "ifid_flush", ifid_flush, 1);
    chk("R9", "idex_bubble", idex_bubble, 1);
    tick(); redirect = 1'b0; nop(); #1;
    chk("R9", "flushed slot empty", fwd_a_sel, 0);
    drain();
    put(1, 5'd1, 1, 5'd2, 1, 5'd7, 1, 0); redirect = 1'b1; tick();
    redirect = 1'b0;
    put(1, 5'd7, 1, 5'd7, 1, 5'd8, 1, 0); tick();
    chk("R9", "discarded writer not bypassed a", fwd_a_sel, 0);
    chk("R9", "discarded writer not bypassed b", fwd_b_sel, 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    redirect = 1'b0;
    nop();
    repeat (3) tick();
    t_reset();
    rst_n = 1'b1;
    tick(); tick();
    t_reset();
    t_near_bypass();
    t_far_bypass();
    t_priority();
    t_unused();
    t_zero_and_nowen();
    t_load_use();
    t_load_gap();
    t_flush();
    drain();
    summary();
    $finish;
  end

endmodule